// File: doc/BRIEF.md
# Round-Robin Slave Port Arbiter

This block decides which master owns one slave port of a multi-master bus matrix. Each master offers a request, an address and a last-beat flag. A decoder for each master compares that master's address against the slave's address window. A master whose request is raised and whose address hits the window is eligible. A rotating-priority arbiter then grants one eligible master at a time. The grant is registered and stays with its owner until a transfer boundary.

A transfer boundary is either the owner's last beat or the end of a programmable slot of beats. The slot limit breaks long bursts so that a streaming master cannot hold the slave for ever. When nothing is eligible, the port is parked in one of three ways: ungranted, on the most recent owner, or on a configured master. Parking on a master lets that master start without an arbitration cycle. Data multiplexing and bus timing beyond the grant belong to the surrounding matrix.

Top module: `rr_slave_arbiter`

## Requirements
- R1: After a synchronous reset, `mst_gnt` is zero and `gnt_valid` is low. The parking mode resets to ungranted (0), the fixed index to 0 and the slot limit to `DEF_LIMIT`. The recorded last owner resets to index `N_MST-1`.
- R2: Master i is eligible only when `mst_req[i]` is high and (address & `SLV_MASK`) == `SLV_BASE`. Its address is bits [i*AW +: AW] of `mst_addr`. A request whose address misses the window is ignored.
- R3: When arbitration picks among eligible masters, the search starts at the index after the recorded last owner and wraps from `N_MST-1` to 0. The first eligible master found wins, and it becomes the recorded last owner.
- R4: A grant appears at the clock edge after the eligibility that causes it. While the owner stays eligible and no boundary occurs, the grant does not change.
- R5: A beat of the owner (`xfer_beat` high) with the owner's `mst_last` bit set ends the grant. The next grant is chosen by round robin at that same edge.
- R6: With a nonzero slot limit L, the owner's L-th beat since it was granted ends the grant even without a last flag. The beat count restarts from zero on every new grant.
- R7: A slot limit of 0 never breaks a burst.
- R8: In mode 0 (or the unused code 3), the port goes ungranted at any edge where no master is eligible. The first access after that takes one arbitration cycle.
- R9: In mode 1, the grant moves to the recorded last owner at any edge where no master is eligible. It stays there while none is eligible.
- R10: In mode 2, the grant moves to master `cfg_fixed` at any edge where no master is eligible. An index of `N_MST` or more leaves the port ungranted.
- R11: `mst_gnt` has at most one bit set. `gnt_valid` equals the OR of `mst_gnt`, and `gnt_id` gives the index of the set bit.
- R12: A write with `cfg_we` high loads the mode, fixed index and limit at that clock edge. The new values govern decisions from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | N_MST | Request per master |
| mst_addr | input | N_MST*AW | Address per master, master i at [i*AW +: AW] |
| mst_last | input | N_MST | Last-beat flag per master |
| xfer_beat | input | 1 | The slave accepted a beat of the granted master this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Parking mode: 0 ungranted, 1 last owner, 2 fixed, 3 ungranted |
| cfg_fixed | input | IDW | Master index used for fixed parking |
| cfg_limit | input | SW | Slot beat limit, 0 disables breaking |
| mst_gnt | output | N_MST | One-hot grant vector, registered |
| gnt_valid | output | 1 | A master holds the grant |
| gnt_id | output | IDW | Index of the granted master |

## Verification
The bench builds the block with four masters, 12-bit addresses and a 4-bit slot limit. The window hits when address bits 11:10 are 01. Four masters make it possible to reach the wrap from index 3 to 0 and to see a skipped requester. They also show a master that requests with an address outside the window. A slot limit of two gives a grant that alternates every two beats between two streaming masters, and that run shows the beat count restarting on each new grant. Each parking mode is entered from idle, so the grant can be watched moving to the expected park target.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;
endpackage

// File: rtl/mst_addr_decode.sv
module mst_addr_decode #(
  parameter int          AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] MASK = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb hit = ((addr & MASK) == BASE);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N   = 10,
  parameter int IDW = 4
) (
  input  logic [N-1:0]   cand,
  input  logic [IDW-1:0] prev_id,
  output logic           found,
  output logic [IDW-1:0] win_id
);
  // rotate search: prev_id+1, prev_id+2, ... wrapping, prev_id itself last
  always_comb begin
    found  = 1'b0;
    win_id = '0;
    for (int k = 1; k <= N; k++) begin
      int t;
      t = int'(prev_id) + k;
      if (t >= N) t = t - N;
      if (!found && (t < N)) begin
        if (cand[t]) begin
          found  = 1'b1;
          win_id = IDW'(t);
        end
      end
    end
  end
endmodule

// File: rtl/slot_ctr.sv
module slot_ctr #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [SW-1:0] limit,
  output logic          expire
);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  // the beat that arrives when cnt_q = limit-1 is the last one of the slot
  always_comb expire = (limit != '0) && (cnt_q >= (limit - 1'b1));
endmodule

// File: rtl/rr_slave_arbiter.sv
module rr_slave_arbiter
  import arb_pkg::*;
#(
  parameter int            N_MST     = 10,
  parameter int            AW        = 32,
  parameter int            SW        = 8,
  parameter logic [AW-1:0] SLV_BASE  = AW'(32'h2000_0000),
  parameter logic [AW-1:0] SLV_MASK  = AW'(32'hF000_0000),
  parameter logic [SW-1:0] DEF_LIMIT = '0,
  localparam int           IDW       = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_MST-1:0]    mst_req,
  input  logic [N_MST*AW-1:0] mst_addr,
  input  logic [N_MST-1:0]    mst_last,
  input  logic                xfer_beat,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_mode,
  input  logic [IDW-1:0]      cfg_fixed,
  input  logic [SW-1:0]       cfg_limit,
  output logic [N_MST-1:0]    mst_gnt,
  output logic                gnt_valid,
  output logic [IDW-1:0]      gnt_id
);
  localparam logic [IDW-1:0] LAST_IDX = IDW'(N_MST - 1);

  // configuration registers
  park_mode_e     mode_q;
  logic [IDW-1:0] fixed_q;
  logic [SW-1:0]  limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PARK_NONE;
      fixed_q <= '0;
      limit_q <= DEF_LIMIT;
    end else if (cfg_we) begin
      mode_q  <= park_mode_e'(cfg_mode);
      fixed_q <= cfg_fixed;
      limit_q <= cfg_limit;
    end
  end

  // per-master window decode
  logic [N_MST-1:0] hit;
  logic [N_MST-1:0] elig;

  for (genvar g = 0; g < N_MST; g++) begin : g_dec
    mst_addr_decode #(
      .AW  (AW),
      .BASE(SLV_BASE),
      .MASK(SLV_MASK)
    ) u_dec (
      .addr(mst_addr[g*AW +: AW]),
      .hit (hit[g])
    );
  end

  always_comb elig = mst_req & hit;

  // grant state
  logic [N_MST-1:0] gnt_q;
  logic             vld_q;
  logic [IDW-1:0]   own_q;
  logic [IDW-1:0]   prev_q;

  logic           pick_found;
  logic [IDW-1:0] pick_id;

  rr_pick #(
    .N  (N_MST),
    .IDW(IDW)
  ) u_pick (
    .cand   (elig),
    .prev_id(prev_q),
    .found  (pick_found),
    .win_id (pick_id)
  );

  logic own_elig, own_last, slot_done, boundary, keep;

  always_comb begin
    own_elig = vld_q && elig[own_q];
    own_last = mst_last[own_q];
    boundary = own_elig && xfer_beat && (own_last || slot_done);
    keep     = own_elig && !boundary;
  end

  slot_ctr #(
    .SW(SW)
  ) u_slot (
    .clk   (clk),
    .rst   (rst),
    .clear (!keep),
    .step  (keep && xfer_beat),
    .limit (limit_q),
    .expire(slot_done)
  );

  // next grant selection
  logic           nxt_vld;
  logic [IDW-1:0] nxt_id;
  logic           fixed_ok;

  always_comb begin
    fixed_ok = (int'(fixed_q) < N_MST);
    nxt_vld  = 1'b0;
    nxt_id   = '0;
    if (keep) begin
      nxt_vld = 1'b1;
      nxt_id  = own_q;
    end else if (pick_found) begin
      nxt_vld = 1'b1;
      nxt_id  = pick_id;
    end else begin
      unique case (mode_q)
        PARK_LAST: begin
          nxt_vld = 1'b1;
          nxt_id  = prev_q;
        end
        PARK_FIXED: begin
          nxt_vld = fixed_ok;
          nxt_id  = fixed_ok ? fixed_q : '0;
        end
        default: begin
          nxt_vld = 1'b0;
          nxt_id  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      vld_q  <= 1'b0;
      own_q  <= '0;
      prev_q <= LAST_IDX;
    end else begin
      vld_q <= nxt_vld;
      own_q <= nxt_id;
      gnt_q <= nxt_vld ? (N_MST'(1) << nxt_id) : '0;
      if (keep)            prev_q <= own_q;
      else if (pick_found) prev_q <= pick_id;
    end
  end

  assign mst_gnt   = gnt_q;
  assign gnt_valid = vld_q;
  assign gnt_id    = own_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N   = 10,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   gnt,
  input logic           gnt_valid,
  input logic [IDW-1:0] gnt_id,
  input logic [N-1:0]   elig,
  input logic           beat,
  input logic [1:0]     mode,
  input logic [IDW-1:0] fixed_id
);
  logic none_elig;
  always_comb none_elig = (elig == '0);

  // R11: grant vector shape
  a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  a_r11_valid: assert property (@(posedge clk) disable iff (rst)
    gnt_valid == (gnt != '0));
  a_r11_index: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> gnt[gnt_id]);

  // R2: if anyone was eligible, the next owner was one of them
  a_r2_eligible_win: assert property (@(posedge clk) disable iff (rst)
    !none_elig |=> ((gnt & $past(elig)) != '0));

  // R4: an eligible owner without a beat keeps the grant
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && elig[gnt_id] && !beat) |=> (gnt_valid && gnt_id == $past(gnt_id)));

  // R8: ungranted parking
  a_r8_idle_none: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd0 || mode == 2'd3) && none_elig) |=> !gnt_valid);

  // R9: stay with the last owner while idle
  a_r9_park_last: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && none_elig && gnt_valid) |=> (gnt_valid && gnt_id == $past(gnt_id)));

  // R10: fixed parking target
  a_r10_park_fixed: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && none_elig && int'(fixed_id) < N) |=> (gnt_valid && gnt_id == $past(fixed_id)));
endmodule

bind rr_slave_arbiter arb_checker #(
  .N  (N_MST),
  .IDW(IDW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .gnt      (mst_gnt),
  .gnt_valid(gnt_valid),
  .gnt_id   (gnt_id),
  .elig     (elig),
  .beat     (xfer_beat),
  .mode     (mode_q),
  .fixed_id (fixed_q)
);

// File: tb/sim_rr_slave_arbiter.sv
module sim_rr_slave_arbiter;
  localparam int NM  = 4;
  localparam int AWB = 12;
  localparam int SWB = 4;
  localparam int IDB = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NM-1:0]     mst_req = '0;
  logic [NM*AWB-1:0] mst_addr = '0;
  logic [NM-1:0]     mst_last = '0;
  logic              xfer_beat = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_mode = '0;
  logic [IDB-1:0]    cfg_fixed = '0;
  logic [SWB-1:0]    cfg_limit = '0;
  logic [NM-1:0]     mst_gnt;
  logic              gnt_valid;
  logic [IDB-1:0]    gnt_id;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rr_slave_arbiter #(
    .N_MST    (NM),
    .AW       (AWB),
    .SW       (SWB),
    .SLV_BASE (12'h400),
    .SLV_MASK (12'hC00),
    .DEF_LIMIT(4'd0)
  ) u0 (
    .clk(clk), .rst(rst), .mst_req(mst_req), .mst_addr(mst_addr),
    .mst_last(mst_last), .xfer_beat(xfer_beat), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_fixed(cfg_fixed), .cfg_limit(cfg_limit),
    .mst_gnt(mst_gnt), .gnt_valid(gnt_valid), .gnt_id(gnt_id)
  );

  // vector: req[16:13] hit[12:9] last[8:5] beat[4] expected grant[3:0]
  localparam logic [16:0] VEC [10] = '{
    {4'b0011, 4'b1111, 4'b0000, 1'b0, 4'b0001},  // R3 first pick from index 0
    {4'b0011, 4'b1111, 4'b0000, 1'b1, 4'b0001},  // R4 hold mid burst
    {4'b0011, 4'b1111, 4'b0001, 1'b1, 4'b0010},  // R5 last beat, rotate
    {4'b0011, 4'b1111, 4'b0010, 1'b1, 4'b0001},  // R3 wrap back to 0
    {4'b0010, 4'b1111, 4'b0000, 1'b0, 4'b0010},  // R4 owner dropped
    {4'b0110, 4'b1011, 4'b0010, 1'b1, 4'b0010},  // R2 master 2 misses window
    {4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0000},  // R8 idle ungranted
    {4'b1000, 4'b1111, 4'b0000, 1'b0, 4'b1000},  // R8 one cycle to grant
    {4'b1001, 4'b1111, 4'b1000, 1'b1, 4'b0001},  // R3 wrap 3 -> 0
    {4'b1111, 4'b0000, 4'b0000, 1'b0, 4'b0000}   // R2 all miss
  };

  task automatic drive(input logic [3:0] r, input logic [3:0] h,
                       input logic [3:0] l, input logic b);
    mst_req = r;
    for (int i = 0; i < NM; i++)
      mst_addr[i*AWB +: AWB] = h[i] ? 12'h400 : 12'h000;
    mst_last  = l;
    xfer_beat = b;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [IDB-1:0] eid;
    eid = '0;
    for (int i = 0; i < NM; i++) if (exp[i]) eid = IDB'(i);
    total++;
    if (mst_gnt !== exp || gnt_valid !== (exp != '0) ||
        ((exp != '0) && gnt_id !== eid)) begin
      bad++;
      $display("FAIL %s: gnt=%b valid=%b id=%0d expected gnt=%b id=%0d",
               tag, mst_gnt, gnt_valid, gnt_id, exp, eid);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; mst_req = '0; mst_last = '0; xfer_beat = 1'b0; cfg_we = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  // R12: one write edge, grant logic still idle
  task automatic cfg_write(input logic [1:0] m, input logic [IDB-1:0] f,
                           input logic [SWB-1:0] lim);
    cfg_we = 1'b1; cfg_mode = m; cfg_fixed = f; cfg_limit = lim;
    mst_req = '0;
    @(posedge clk);
    #2 cfg_we = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    chk("R1 reset state", 4'b0000);

    for (int v = 0; v < 10; v++) begin
      drive(VEC[v][16:13], VEC[v][12:9], VEC[v][8:5], VEC[v][4]);
      chk($sformatf("R2/R3/R4/R5/R8 vector %0d", v), VEC[v][3:0]);
    end

    // R6: slot limit 2, two streaming masters alternate every two beats
    do_reset();
    cfg_write(2'd0, 2'd0, 4'd2);
    drive(4'b0110, 4'b1111, 4'b0000, 1'b1); chk("R6 first grant", 4'b0010);
    drive(4'b0110, 4'b1111, 4'b0000, 1'b1); chk("R6 beat 1 held", 4'b0010);
    drive(4'b0110, 4'b1111, 4'b0000, 1'b1); chk("R6 break after 2", 4'b0100);
    drive(4'b0110, 4'b1111, 4'b0000, 1'b1); chk("R6 reload held", 4'b0100);
    drive(4'b0110, 4'b1111, 4'b0000, 1'b1); chk("R6 break back", 4'b0010);

    // R7: limit 0 never breaks
    do_reset();
    drive(4'b0110, 4'b1111, 4'b0000, 1'b1); chk("R7 first grant", 4'b0010);
    for (int k = 0; k < 6; k++) begin
      drive(4'b0110, 4'b1111, 4'b0000, 1'b1);
      chk("R7 no break", 4'b0010);
    end

    // R9: park on most recent owner (index 3 after reset)
    do_reset();
    cfg_write(2'd1, 2'd0, 4'd0);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R9 park on reset owner", 4'b1000);
    drive(4'b0100, 4'b1111, 4'b0000, 1'b0); chk("R9 grant m2", 4'b0100);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R9 stay m2", 4'b0100);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R9 still m2", 4'b0100);
    drive(4'b0001, 4'b1111, 4'b0000, 1'b0); chk("R9 move to m0", 4'b0001);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R9 stay m0", 4'b0001);

    // R10: fixed park on index 2
    do_reset();
    cfg_write(2'd2, 2'd2, 4'd0);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R10 park fixed", 4'b0100);
    drive(4'b0001, 4'b1111, 4'b0000, 1'b0); chk("R10 m0 takes", 4'b0001);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R10 return fixed", 4'b0100);
    drive(4'b0100, 4'b1111, 4'b0000, 1'b1); chk("R10 parked owner keeps", 4'b0100);

    // R12: code 3 behaves as ungranted parking
    cfg_write(2'd3, 2'd2, 4'd0);
    drive(4'b0000, 4'b1111, 4'b0000, 1'b0); chk("R12 mode 3 ungranted", 4'b0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule